// File: doc/BRIEF.md
# Modulo Circular Address Generator

This block forms effective addresses for a circular buffer that is walked by a pointer register. Each access supplies the pointer's current value, a signed step, a two-bit mode code and the index of the pointer in use. The block adds the step to the pointer. If the sum has left the programmed window, the block folds it back into the window. It then decides what goes onto the memory address bus and whether the result is written back to the pointer.

The window is described by an inclusive start address, an inclusive end address and the index of the one pointer it belongs to. These three settings and an enable bit sit in registers that load on a configuration strobe. The address path itself is purely combinational, so an access is resolved in the same cycle it is presented. The sign of the step sets the direction. A positive step tests against the end address, and a negative step tests against the start address. Both tests use strict comparisons, so a step that lands past the boundary is folded as well as one that lands just beyond it.

Top module: `mod_agu`

## Requirements
- R1: After reset the modulo window is disabled, so every address is the plain sum ptr_i + step_i modulo 2^AW with no folding.
- R2: The window settings (cfg_en_i, cfg_sel_i, cfg_start_i, cfg_end_i) load only on a rising clock edge where cfg_we_i is high and apply from the next cycle. Values presented while cfg_we_i is low have no effect.
- R3: With a positive step, a sum strictly greater than the end address has the buffer length (end - start + 1) subtracted. A sum equal to the end address is left unchanged.
- R4: With a negative step, a sum strictly less than the start address has the buffer length added. A sum equal to the start address is left unchanged.
- R5: Folding applies only when the window is enabled and ptr_sel_i equals the programmed pointer index. Otherwise the plain sum is used.
- R6: Pre-modify (mode code 1): ea_o and wb_data_o both equal the corrected sum, and wb_en_o is 1.
- R7: Post-modify (mode code 2): ea_o equals ptr_i, wb_data_o equals the corrected sum, and wb_en_o is 1.
- R8: Register-plus-offset (mode code 3): ea_o equals the corrected sum and wb_en_o is 0, so the pointer keeps its value.
- R9: Plain indirect (mode code 0): ea_o equals ptr_i and wb_en_o is 0.
- R10: A zero step never triggers folding, even if the pointer itself lies outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the settings registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load strobe for the window settings |
| cfg_en_i | input | 1 | Window enable value to load |
| cfg_sel_i | input | SW | Pointer index the window belongs to |
| cfg_start_i | input | AW | Inclusive lower boundary address |
| cfg_end_i | input | AW | Inclusive upper boundary address |
| ptr_sel_i | input | SW | Index of the pointer used by this access |
| ptr_i | input | AW | Current pointer value |
| step_i | input | AW | Signed two's-complement modify amount |
| mode_i | input | 2 | Mode: 0 plain, 1 pre-modify, 2 post-modify, 3 offset |
| ea_o | output | AW | Effective address |
| wb_data_o | output | AW | Corrected value for the pointer |
| wb_en_o | output | 1 | Pointer write-back enable |

## Verification
The bench drives both directions with steps that land exactly on a boundary, one address past it, and several addresses past it. An equality-based wrap test would miss the overshoot cases, and an inclusive compare would fold the exact-landing ones. It switches modes to catch a design that writes back in offset mode or that puts the modified value on the bus in post-modify mode. It also uses a mismatched pointer index, a disabled window, a zero step, and a settings change presented without the strobe. A design that folds too eagerly or latches settings too early would change the address in those cases. A randomized sweep against a behavioural model covers the remaining combinations.

// File: rtl/mod_agu_pkg.sv
package mod_agu_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'd0,
    MODE_PRE    = 2'd1,
    MODE_POST   = 2'd2,
    MODE_OFFSET = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/mod_agu_cfg.sv
module mod_agu_cfg #(
  parameter int AW = 16,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          en_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  output logic          en_o,
  output logic [SW-1:0] sel_o,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] end_o,
  output logic [AW-1:0] len_o
);
  logic          en_q;
  logic [SW-1:0] sel_q;
  logic [AW-1:0] start_q, end_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      sel_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      len_q   <= AW'(1);
    end else if (we_i) begin
      en_q    <= en_i;
      sel_q   <= sel_i;
      start_q <= start_i;
      end_q   <= end_i;
      len_q   <= end_i - start_i + AW'(1);  // length precomputed off the address path
    end
  end

  assign en_o    = en_q;
  assign sel_o   = sel_q;
  assign start_o = start_q;
  assign end_o   = end_q;
  assign len_o   = len_q;

  // R2
  cfg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (en_o == $past(en_i) && start_o == $past(start_i) && end_o == $past(end_i)));
  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(en_o) && $stable(start_o) && $stable(end_o) && $stable(sel_o)));
endmodule

// File: rtl/mod_agu_wrap.sv
module mod_agu_wrap #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] step_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] sum;
  logic          step_pos, step_neg;
  logic          over_hi, under_lo;

  assign sum      = ptr_i + step_i;
  assign step_neg = step_i[AW-1];
  assign step_pos = !step_i[AW-1] && (|step_i);
  // strict compares: overshoot folds, exact landing does not
  assign over_hi  = active_i && step_pos && (sum > end_i);
  assign under_lo = active_i && step_neg && (sum < start_i);

  always_comb begin
    addr_o = sum;
    if (over_hi)       addr_o = sum - len_i;
    else if (under_lo) addr_o = sum + len_i;
  end

  // R3
  up_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && step_pos && ptr_i >= start_i && ptr_i <= end_i && step_i < len_i)
      |-> (addr_o >= start_i && addr_o <= end_i));
  // R4
  down_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && step_neg && ptr_i >= start_i && ptr_i <= end_i && (-step_i) < len_i)
      |-> (addr_o >= start_i && addr_o <= end_i));
  // R10
  zero_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == '0) |-> (addr_o == ptr_i));
endmodule

// File: rtl/mod_agu_route.sv
module mod_agu_route
  import mod_agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] corr_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] wb_data_o,
  output logic          wb_en_o
);
  agu_mode_e mode;
  assign mode = agu_mode_e'(mode_i);

  always_comb begin
    wb_data_o = corr_i;
    unique case (mode)
      MODE_PRE:    begin ea_o = corr_i; wb_en_o = 1'b1; end
      MODE_POST:   begin ea_o = ptr_i;  wb_en_o = 1'b1; end
      MODE_OFFSET: begin ea_o = corr_i; wb_en_o = 1'b0; end
      default:     begin ea_o = ptr_i;  wb_en_o = 1'b0; end
    endcase
  end

  // R8 R9
  wb_only_modify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (mode_i == 2'd1 || mode_i == 2'd2));
  // R7
  post_ea_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |-> (ea_o == ptr_i && wb_data_o == corr_i));
  // R6
  pre_ea_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |-> (ea_o == wb_data_o));
endmodule

// File: rtl/mod_agu.sv
module mod_agu #(
  parameter int AW = 16,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_en_i,
  input  logic [SW-1:0] cfg_sel_i,
  input  logic [AW-1:0] cfg_start_i,
  input  logic [AW-1:0] cfg_end_i,
  input  logic [SW-1:0] ptr_sel_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] step_i,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] wb_data_o,
  output logic          wb_en_o
);
  logic          en_q;
  logic [SW-1:0] sel_q;
  logic [AW-1:0] start_q, end_q, len_q;
  logic          active;
  logic [AW-1:0] corr;

  mod_agu_cfg #(.AW(AW), .SW(SW)) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .en_i(cfg_en_i), .sel_i(cfg_sel_i),
    .start_i(cfg_start_i), .end_i(cfg_end_i),
    .en_o(en_q), .sel_o(sel_q), .start_o(start_q), .end_o(end_q), .len_o(len_q)
  );

  assign active = en_q && (ptr_sel_i == sel_q);

  mod_agu_wrap #(.AW(AW)) i_wrap (
    .clk_i, .rst_ni,
    .active_i(active), .ptr_i, .step_i,
    .start_i(start_q), .end_i(end_q), .len_i(len_q),
    .addr_o(corr)
  );

  mod_agu_route #(.AW(AW)) i_route (
    .clk_i, .rst_ni,
    .mode_i, .ptr_i, .corr_i(corr),
    .ea_o, .wb_data_o, .wb_en_o
  );

  // R5
  no_fold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active) |-> (wb_data_o == AW'(ptr_i + step_i)));
endmodule

// File: tb/test_mod_agu.sv
module test_mod_agu;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int SW = 4;
  localparam int MASK = (1 << AW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0, cfg_en_i = 1'b0;
  logic [SW-1:0] cfg_sel_i = '0, ptr_sel_i = '0;
  logic [AW-1:0] cfg_start_i = '0, cfg_end_i = '0, ptr_i = '0, step_i = '0;
  logic [1:0]    mode_i = '0;
  logic [AW-1:0] ea_o, wb_data_o;
  logic          wb_en_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // model state
  int m_en = 0, m_sel = 0, m_start = 0, m_end = 0;

  mod_agu #(.AW(AW), .SW(SW)) i_mod_agu (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int model_corr(int ptr, int step, int sel);
    int sum = (ptr + step) & MASK;
    int len = m_end - m_start + 1;
    if (m_en != 0 && sel == m_sel) begin
      if (step > 0 && sum > m_end) sum = sum - len;
      else if (step < 0 && sum < m_start) sum = sum + len;
    end
    return sum & MASK;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(int en, int sel, int s, int e);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_en_i = en[0]; cfg_sel_i = sel[SW-1:0];
    cfg_start_i = s[AW-1:0]; cfg_end_i = e[AW-1:0];
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    m_en = en; m_sel = sel; m_start = s; m_end = e;
  endtask

  // drive one access and compare against the model
  task automatic access(string req, int ptr, int step, int mode, int sel);
    int c, exp_ea, exp_wbe;
    @(negedge clk_i);
    ptr_i = ptr[AW-1:0]; step_i = step[AW-1:0];
    mode_i = mode[1:0]; ptr_sel_i = sel[SW-1:0];
    #(CLK_P/4);
    c = model_corr(ptr, step, sel);
    case (mode)
      1: begin exp_ea = c;   exp_wbe = 1; end
      2: begin exp_ea = ptr; exp_wbe = 1; end
      3: begin exp_ea = c;   exp_wbe = 0; end
      default: begin exp_ea = ptr; exp_wbe = 0; end
    endcase
    check({req, " ea"}, int'(ea_o), exp_ea);
    check({req, " wb_en"}, int'(wb_en_o), exp_wbe);
    check({req, " wb_data"}, int'(wb_data_o), c);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset leaves folding off
    access("R1", 'h10F, 5, 1, 0);
    check("R1 literal", int'(ea_o), 'h114);

    write_cfg(1, 2, 'h100, 'h10F);
    // R3 up: on, one past, several past
    access("R3 on",    'h10E, 1, 1, 2);
    check("R3 on literal", int'(ea_o), 'h10F);
    access("R3 one",   'h10E, 2, 1, 2);
    check("R3 one literal", int'(ea_o), 'h100);
    access("R3 many",  'h10E, 5, 1, 2);
    check("R3 many literal", int'(ea_o), 'h103);
    // R4 down
    access("R4 on",    'h101, -1, 1, 2);
    check("R4 on literal", int'(ea_o), 'h100);
    access("R4 one",   'h101, -2, 1, 2);
    check("R4 one literal", int'(ea_o), 'h10F);
    access("R4 many",  'h101, -5, 1, 2);
    check("R4 many literal", int'(ea_o), 'h10C);
    // R7 post
    access("R7", 'h10E, 3, 2, 2);
    check("R7 literal", int'(wb_data_o), 'h101);
    // R8 offset
    access("R8", 'h101, -3, 3, 2);
    check("R8 literal", int'(ea_o), 'h10E);
    // R9 plain
    access("R9", 'h10E, 3, 0, 2);
    // R6 pre
    access("R6", 'h108, 9, 1, 2);
    // R5 mismatched pointer
    access("R5 sel", 'h10E, 5, 1, 3);
    check("R5 sel literal", int'(ea_o), 'h113);
    // R10 zero step with pointer outside window
    access("R10", 'h120, 0, 1, 2);
    check("R10 literal", int'(ea_o), 'h120);
    // R2 settings without strobe are ignored
    @(negedge clk_i);
    cfg_en_i = 1'b0; cfg_sel_i = 4'd7; cfg_start_i = 'h0; cfg_end_i = 'hFFF;
    @(negedge clk_i);
    access("R2 ignore", 'h10E, 5, 1, 2);
    check("R2 ignore literal", int'(ea_o), 'h103);
    // R5 disabled window
    write_cfg(0, 2, 'h100, 'h10F);
    access("R5 off", 'h10E, 5, 1, 2);
    check("R5 off literal", int'(ea_o), 'h113);

    // sweep against the model
    write_cfg(1, 5, 'h340, 'h35B);
    for (int i = 0; i < 400; i++) begin
      int len = m_end - m_start + 1;
      int p = m_start + $urandom_range(0, len - 1);
      int s = $urandom_range(0, len - 1);
      int sel = ($urandom_range(0, 3) == 0) ? 1 : 5;
      if ($urandom_range(0, 1) == 1) s = -s;
      access("R3 R4 R6 R7 R8 R9 sweep", p, s, $urandom_range(0, 3), sel);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule